// File: doc/BRIEF.md
# Set/Reset Pulse Decoder with Loss-of-Link Watchdog

This block sits on the receiving side of an isolated one-bit link. The sender reports every change of its input as a short pulse on one of two lines. One line means "go high" and the other means "go low". When the input has been idle for a while, the sender repeats the current level as a refresh pulse. The decoder turns these two pulse lines back into one level on `dout` and holds that level between pulses.

A watchdog counts the clock cycles since the last valid pulse. If `TIMEOUT_CYCLES` cycles go by with no valid pulse, the decoder concludes that the sender is unpowered or broken. It then forces `dout` to a failsafe high level and raises `link_fault`. The next valid pulse clears the fault and puts its own level on the output. `TIMEOUT_CYCLES` must be larger than the sender's refresh interval, so that a healthy link that is only idle never trips the watchdog. As an example, a 5 µs timeout against a 2 µs refresh gives 1000 cycles at 200 MHz. A cycle in which both lines are high is invalid: it is ignored and does not restart the watchdog.

The control is a three-state machine:
- HOLD_HI: the output is high and the link is healthy. This is also the state after reset.
- HOLD_LO: the output is low and the link is healthy.
- FAILSAFE: the output is forced high and `link_fault` is set.

The machine makes these transitions:
- A valid set pulse moves it to HOLD_HI from any state.
- A valid clear pulse moves it to HOLD_LO from any state.
- Watchdog expiry moves it from HOLD_HI or HOLD_LO to FAILSAFE.
- Any other cycle keeps the current state.

Top module: `pulse_link_rx`

## Requirements
- R1: When `set_pulse`=1 and `clr_pulse`=0 at a rising clock edge, `dout` reads 1 after that edge.
- R2: When `clr_pulse`=1 and `set_pulse`=0 at a rising clock edge, `dout` reads 0 after that edge.
- R3: In cycles with no valid pulse and no watchdog expiry, `dout` and `link_fault` keep their values.
- R4: A cycle with both `set_pulse` and `clr_pulse` at 1 leaves `dout` unchanged and does not restart the watchdog count.
- R5: After `TIMEOUT_CYCLES` consecutive edges without a valid pulse, `dout`=1 and `link_fault`=1 from that edge on.
- R6: A valid pulse restarts the watchdog count. A run of `TIMEOUT_CYCLES`-1 idle edges after a pulse does not raise `link_fault`.
- R7: While `link_fault`=1, the first valid pulse clears `link_fault` at its edge and sets `dout` to its own level (set gives 1, clear gives 0).
- R8: During and right after synchronous reset (`rst`=1), `dout`=1 and `link_fault`=0. The watchdog count starts at zero on the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse | input | 1 | Pulse that requests a high output |
| clr_pulse | input | 1 | Pulse that requests a low output |
| dout | output | 1 | Decoded level; forced high while the link is in fault |
| link_fault | output | 1 | High while the watchdog has expired and no valid pulse has come since |

## Verification
The bench uses a small timeout and a cycle model computed from the requirements. It sweeps the idle gap after each pulse polarity from zero up to past the timeout. The gap of one below the timeout and the gap equal to the timeout separate a correct restart from an off-by-one in the expiry count. From each of the three states it applies all four input combinations, which tells a correct priority apart from a set-wins or clear-wins treatment of the invalid case. A run of nothing but conflicting cycles shows whether those cycles wrongly feed the watchdog.

// File: rtl/pulse_link_rx_pkg.sv
package pulse_link_rx_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_SET  = 2'b01,
        EV_CLR  = 2'b10,
        EV_BAD  = 2'b11
    } rx_event_t;

    typedef enum logic [1:0] {
        HOLD_HI  = 2'b00,
        HOLD_LO  = 2'b01,
        FAILSAFE = 2'b10
    } rx_state_t;

endpackage

// File: rtl/pulse_link_rx_qualify.sv
module pulse_link_rx_qualify
    import pulse_link_rx_pkg::*;
(
    input  logic      set_in,
    input  logic      clr_in,
    output rx_event_t evt,
    output logic      valid
);
    always_comb begin
        unique case ({clr_in, set_in})
            2'b00:   evt = EV_NONE;
            2'b01:   evt = EV_SET;
            2'b10:   evt = EV_CLR;
            default: evt = EV_BAD;
        endcase
    end

    assign valid = (evt == EV_SET) || (evt == EV_CLR);
endmodule

// File: rtl/pulse_link_rx_watchdog.sv
module pulse_link_rx_watchdog #(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (kick) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign expire = (idle_cnt == LAST) && !kick;

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        idle_cnt <= LIMIT);
    p_kick_restart_r6: assert property (@(posedge clk) disable iff (rst)
        kick |=> (idle_cnt == '0));
    p_idle_advance_r4: assert property (@(posedge clk) disable iff (rst)
        (!kick && idle_cnt != LIMIT) |=> (idle_cnt == $past(idle_cnt) + 1'b1));
endmodule

// File: rtl/pulse_link_rx_fsm.sv
module pulse_link_rx_fsm
    import pulse_link_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_event_t evt,
    input  logic      wd_expire,
    output logic      dout,
    output logic      link_fault
);
    rx_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (evt)
            EV_SET:  state_nx = HOLD_HI;
            EV_CLR:  state_nx = HOLD_LO;
            default: if (wd_expire && state != FAILSAFE) state_nx = FAILSAFE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HOLD_HI;
        else     state <= state_nx;
    end

    always_comb begin
        dout       = 1'b1;
        link_fault = 1'b0;
        unique case (state)
            HOLD_HI:  begin dout = 1'b1; link_fault = 1'b0; end
            HOLD_LO:  begin dout = 1'b0; link_fault = 1'b0; end
            FAILSAFE: begin dout = 1'b1; link_fault = 1'b1; end
            default:  begin dout = 1'b1; link_fault = 1'b0; end
        endcase
    end

    p_set_high_r1: assert property (@(posedge clk) disable iff (rst)
        (evt == EV_SET) |=> dout);
    p_clr_low_r2: assert property (@(posedge clk) disable iff (rst)
        (evt == EV_CLR) |=> !dout);
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (evt == EV_NONE && !wd_expire) |=> ($stable(dout) && $stable(link_fault)));
    p_bad_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (evt == EV_BAD && !wd_expire) |=> $stable(dout));
    p_expire_fault_r5: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> (link_fault && dout));
    p_fault_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (link_fault && (evt == EV_SET || evt == EV_CLR)) |=> !link_fault);
endmodule

// File: rtl/pulse_link_rx.sv
module pulse_link_rx
    import pulse_link_rx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic dout,
    output logic link_fault
);
    rx_event_t evt;
    logic      evt_valid;
    logic      wd_expire;

    pulse_link_rx_qualify u_qualify (
        .set_in (set_pulse),
        .clr_in (clr_pulse),
        .evt    (evt),
        .valid  (evt_valid)
    );

    pulse_link_rx_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_watchdog (
        .clk    (clk),
        .rst    (rst),
        .kick   (evt_valid),
        .expire (wd_expire)
    );

    pulse_link_rx_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .wd_expire  (wd_expire),
        .dout       (dout),
        .link_fault (link_fault)
    );

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (dout && !link_fault));
endmodule

// File: tb/pulse_link_rx_bench.sv
module pulse_link_rx_bench;
    localparam int T = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_pulse = 1'b0;
    logic clr_pulse = 1'b0;
    logic dout;
    logic link_fault;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int  m_cnt = 0;
    bit  m_out = 1'b1;
    bit  m_fault = 1'b0;

    always #2.5 clk = ~clk;

    pulse_link_rx #(.TIMEOUT_CYCLES(T)) u_pulse_link_rx (
        .clk        (clk),
        .rst        (rst),
        .set_pulse  (set_pulse),
        .clr_pulse  (clr_pulse),
        .dout       (dout),
        .link_fault (link_fault)
    );

    task automatic check(string tag);
        total++;
        if (dout !== m_out || link_fault !== m_fault) begin
            bad++;
            $display("FAIL %s t=%0t dout=%b fault=%b expected dout=%b fault=%b",
                     tag, $time, dout, link_fault, m_out, m_fault);
        end
    endtask

    task automatic step(bit s, bit c, string tag);
        set_pulse = s;
        clr_pulse = c;
        @(posedge clk);
        if (s ^ c) begin
            m_cnt = 0; m_fault = 1'b0; m_out = s;
        end else if (!m_fault) begin
            m_cnt++;
            if (m_cnt >= T) begin m_fault = 1'b1; m_out = 1'b1; end
        end
        #1;
        check(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            if (m_cnt + 1 >= T) step(0, 0, "R5");
            else                step(0, 0, "R3");
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        set_pulse = 1'b0; clr_pulse = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        m_cnt = 0; m_out = 1'b1; m_fault = 1'b0;
        check("R8");
        rst = 1'b0;
    endtask

    // bring the model and design to one of the three states
    task automatic goto_state(int st);
        do_reset();
        if (st == 1) step(0, 1, "R2");
        if (st == 2) idle(T);
    endtask

    initial begin
        @(posedge clk); #1;
        do_reset();
        // R8: watchdog counts from reset, R5: trips after exactly T idle edges
        idle(T + 2);
        // R7: set clears fault with high level
        step(1, 0, "R7");
        idle(T);
        // R7: clear clears fault with low level
        step(0, 1, "R7");
        // R1/R2/R3/R5/R6: idle gap sweep after each polarity
        for (int pol = 0; pol < 2; pol++) begin
            for (int g = 0; g <= T + 1; g++) begin
                if (pol == 1) step(1, 0, "R1");
                else          step(0, 1, "R2");
                idle(g);
            end
        end
        // R6: pulses every T edges (T-1 idle) never trip
        for (int k = 0; k < 5; k++) begin
            step(k[0], !k[0], "R6");
            idle(T - 1);
        end
        // R4: conflicting cycles alone still let the watchdog expire
        step(0, 1, "R2");
        for (int i = 0; i < T + 1; i++) step(1, 1, "R4");
        // exhaustive: each state x each input combination
        for (int st = 0; st < 3; st++) begin
            for (int in = 0; in < 4; in++) begin
                goto_state(st);
                if (in == 3)      step(1, 1, "R4");
                else if (in == 1) step(1, 0, "R1");
                else if (in == 2) step(0, 1, "R2");
                else              step(0, 0, "R3");
                idle(1);
            end
        end
        // R4: conflict after partial idle does not restart the count
        do_reset();
        step(0, 1, "R2");
        idle(T - 2);
        step(1, 1, "R4");
        idle(1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule